// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Paired Enable Writes

This block merges fourteen interrupt sources into a single request line for a processor. Twelve sources are level signals, already synchronous to the block clock, that come straight from peripherals. The other two are asynchronous event pins: a power button and a removable card detector. Each event pin is synchronized, and each rising edge sets a sticky pending flag. The current state of each pin can also be read, separately from its pending flag.

Software reaches the block through a small register bus with two registers, selected by `reg_sel`. The status register (select 0) shows the level inputs, the two pending flags and the two live pin states. A write of 1 to a pending bit clears that flag. The enable register (select 1) holds one enable bit per source. It is changed through paired clear/set bits, so a driver can switch one source on or off without reading the register first. The request output is the registered OR of every enabled, active source.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, every enable bit is 0, both pending flags are 0, `irq_out` is 0 and `reg_rdata` is 0.
- R2: A write to select 1 clears the enable of source k when data bit 2k is 1, and sets it when data bit 2k+1 is 1, for k = 0..13. Data bits 28..31 have no effect.
- R3: If a write to select 1 has both bit 2k and bit 2k+1 at 1, the enable of source k keeps its previous value.
- R4: A read of select 1 returns the enable of source k at bit k. Bits 14..31 read as 0.
- R5: In a status read, bits 0..11 return `lvl_irq[11:0]`. Source order is: bits 0..11 are the level inputs, bit 12 is the button, bit 13 is the card.
- R6: A rising edge on the synchronized button pin sets pending bit 12, and a rising edge on the synchronized card pin sets pending bit 13. A pin change becomes the pending flag on the third rising clock edge after it. The flag stays set after the pin falls.
- R7: Status bit 24 reads 1 while the synchronized button pin is 1 (pressed). Status bit 25 reads 1 while the synchronized card pin is 1 (card absent). Neither bit affects the pending flags or `irq_out`.
- R8: A status write with bit 12 at 1 clears the button pending flag, and one with bit 13 at 1 clears the card pending flag. Each clear leaves the other flag alone. A pin that stays high does not set its flag again. If a new edge arrives in the same cycle as a clear, the flag stays set.
- R9: `irq_out` equals, one clock later, the OR over k of (status bit k AND enable bit k) for k = 0..13.
- R10: When `reg_rd` is high on a clock edge, `reg_rdata` holds the selected register from that edge onward until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = status register, 1 = enable register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| lvl_irq | input | 12 | Synchronous level interrupt sources |
| btn_pin | input | 1 | Asynchronous power-button pin, 1 = pressed |
| card_pin | input | 1 | Asynchronous card-detect pin, 1 = card absent |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
If an enable bit is wrong, it appears in the next enable read and changes `irq_out` one cycle after the affected source becomes active. If a pending flag is wrong, it shows in status bits 12 and 13 from the third edge after a pin change. It shows as well through `irq_out` one edge later, once its enable is set. Holding a pin high after a clear shows whether the block wrongly sets the flag again from the level rather than from an edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic clr,
  output logic pend,
  output logic rise
);
  logic prev;

  assign rise = sync_in & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= sync_in;
      if (rise)     pend <= 1'b1;   // new edge beats a coincident clear
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int N = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [2*N-1:0] ctl,
  output logic [N-1:0]   mask
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic do_clr, do_set;
    assign do_clr = ctl[2*k];
    assign do_set = ctl[2*k+1];

    always_ff @(posedge clk) begin
      if (rst) mask[k] <= 1'b0;
      else if (wr) begin
        case ({do_set, do_clr})
          2'b10:   mask[k] <= 1'b1;
          2'b01:   mask[k] <= 1'b0;
          default: mask[k] <= mask[k];
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_LEVEL       = 12,
  parameter int BUS_W         = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int BTN_LIVE_POS  = 24,
  parameter int CARD_LIVE_POS = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_sel,
  input  logic [BUS_W-1:0]   reg_wdata,
  output logic [BUS_W-1:0]   reg_rdata,
  input  logic [N_LEVEL-1:0] lvl_irq,
  input  logic               btn_pin,
  input  logic               card_pin,
  output logic               irq_out
);
  import irq_agg_pkg::*;

  localparam int N_SRC    = N_LEVEL + 2;
  localparam int BTN_IDX  = N_LEVEL;
  localparam int CARD_IDX = N_LEVEL + 1;
  localparam int CTL_W    = 2 * N_SRC;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  logic btn_s, card_s;
  logic [1:0] pend_q, rise_q, clr_req;
  logic [N_SRC-1:0] mask_q, src_vec;
  logic [BUS_W-1:0] stat_word, mask_word;
  logic unused_hi;

  assign unused_hi = ^reg_wdata[BUS_W-1:CTL_W];

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync_btn (
    .clk(clk), .rst(rst), .d(btn_pin), .q(btn_s));
  irq_sync #(.STAGES(SYNC_STAGES)) u_sync_card (
    .clk(clk), .rst(rst), .d(card_pin), .q(card_s));

  assign clr_req[0] = reg_wr && sel == SEL_STATUS && reg_wdata[BTN_IDX];
  assign clr_req[1] = reg_wr && sel == SEL_STATUS && reg_wdata[CARD_IDX];

  irq_event_latch u_lat_btn (
    .clk(clk), .rst(rst), .sync_in(btn_s), .clr(clr_req[0]),
    .pend(pend_q[0]), .rise(rise_q[0]));
  irq_event_latch u_lat_card (
    .clk(clk), .rst(rst), .sync_in(card_s), .clr(clr_req[1]),
    .pend(pend_q[1]), .rise(rise_q[1]));

  irq_mask_bank #(.N(N_SRC)) u_mask (
    .clk(clk), .rst(rst),
    .wr(reg_wr && sel == SEL_ENABLE),
    .ctl(reg_wdata[CTL_W-1:0]),
    .mask(mask_q));

  assign src_vec = {pend_q[1], pend_q[0], lvl_irq};

  always_comb begin
    stat_word                = '0;
    stat_word[N_SRC-1:0]     = src_vec;
    stat_word[BTN_LIVE_POS]  = btn_s;
    stat_word[CARD_LIVE_POS] = card_s;
    mask_word                = '0;
    mask_word[N_SRC-1:0]     = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= |(src_vec & mask_q);
      if (reg_rd) reg_rdata <= (sel == SEL_ENABLE) ? mask_word : stat_word;
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_SRC = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [31:0]      reg_wdata,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] src_vec,
  input logic [1:0]       pend_q,
  input logic [1:0]       rise_q,
  input logic             irq_out
);
  // R1
  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && pend_q == 2'b00 && !irq_out));

  // R3
  p_both_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && reg_wdata[1:0] == 2'b11) |=> $stable(mask_q[0]));

  // R2
  p_set_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && reg_wdata[3:2] == 2'b10) |=> mask_q[1]);

  // R6
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_q[0] && !(reg_wr && !reg_sel && reg_wdata[12])) |=> pend_q[0]);

  // R8
  p_card_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_wdata[13] && !rise_q[1]) |=> !pend_q[1]);

  // R9
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|(src_vec & mask_q))));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .mask_q(mask_q), .src_vec(src_vec),
  .pend_q(pend_q), .rise_q(rise_q), .irq_out(irq_out));

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] lvl_irq = '0;
  logic        btn_pin = 1'b0, card_pin = 1'b0;
  logic        irq_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_irq(lvl_irq), .btn_pin(btn_pin), .card_pin(card_pin),
    .irq_out(irq_out));

  // {write data, level inputs, expected enables, expected irq}
  localparam logic [58:0] VEC [0:7] = '{
    {32'h0000_0002, 12'h001, 14'h0001, 1'b1},  // R2 set src0
    {32'h0000_0080, 12'h000, 14'h0009, 1'b0},  // R2 set src3
    {32'h0000_0003, 12'h001, 14'h0009, 1'b1},  // R3 both bits
    {32'h0000_0001, 12'h001, 14'h0008, 1'b0},  // R2 clear src0
    {32'h0AAA_AAAA, 12'h800, 14'h3FFF, 1'b1},  // R2 set all
    {32'h0555_5555, 12'hFFF, 14'h0000, 1'b0},  // R2 clear all
    {32'hF000_0000, 12'hFFF, 14'h0000, 1'b0},  // R2 upper bits ignored
    {32'h0080_0000, 12'h800, 14'h0800, 1'b1}   // R2 set src11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic bus_read(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    bus_read(1'b1, rd); check("R1 enables", rd, 32'h0);
    bus_read(1'b0, rd); check("R1 status", rd, 32'h0);

    for (int i = 0; i < 8; i++) begin
      lvl_irq = VEC[i][26:15];
      bus_write(1'b1, VEC[i][58:27]);
      @(negedge clk);
      check($sformatf("R9 vec%0d irq", i), {31'b0, irq_out}, {31'b0, VEC[i][0]});
      bus_read(1'b1, rd);
      check($sformatf("R4 vec%0d enables", i), rd, {18'b0, VEC[i][14:1]});
    end

    // R5 / R10 status shows level inputs
    lvl_irq = 12'hA5C;
    bus_read(1'b0, rd); check("R5 R10 status levels", rd, 32'h0000_0A5C);
    lvl_irq = 12'h000;
    @(negedge clk);
    check("R9 level drop", {31'b0, irq_out}, 32'h0);

    // R6 / R7 button
    btn_pin = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 masked pend", {31'b0, irq_out}, 32'h0);
    bus_read(1'b0, rd); check("R6 R7 button pressed", rd, 32'h0100_1000);
    bus_write(1'b1, 32'h0200_0000);
    @(negedge clk);
    check("R9 button irq", {31'b0, irq_out}, 32'h1);
    btn_pin = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(1'b0, rd); check("R6 sticky after release", rd, 32'h0000_1000);
    bus_write(1'b0, 32'h0000_2000);
    bus_read(1'b0, rd); check("R8 card clear keeps button", rd, 32'h0000_1000);
    bus_write(1'b0, 32'h0000_1000);
    @(negedge clk);
    check("R8 button cleared irq", {31'b0, irq_out}, 32'h0);
    bus_read(1'b0, rd); check("R8 button cleared", rd, 32'h0);

    // R6 timing: pending on third edge
    @(negedge clk);
    card_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_rd = 1'b1; reg_sel = 1'b0;
    @(negedge clk); reg_rd = 1'b0;
    check("R6 not yet pending", reg_rdata & 32'h0000_2000, 32'h0);
    repeat (2) @(negedge clk);
    bus_read(1'b0, rd); check("R6 R7 card absent", rd, 32'h0200_2000);
    check("R7 live no irq", {31'b0, irq_out}, 32'h0);
    bus_write(1'b0, 32'h0000_2000);
    repeat (3) @(negedge clk);
    bus_read(1'b0, rd); check("R8 no relatch while high", rd, 32'h0200_0000);
    card_pin = 1'b0;

    // R1 reset mid-run
    bus_write(1'b1, 32'h0AAA_AAAA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_read(1'b1, rd); check("R1 reset clears enables", rd, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule